// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A single-port synchronous static memory with a registered address, control and write-data interface, built from a small register array. Each access starts with a load cycle that captures an external address. Later cycles either repeat that address or step an internal two-bit beat counter, so a four-beat burst moves through an aligned block of four words. Software never has to use the burst: a fresh address may be loaded on every clock with no idle cycle in between.

Two static mode inputs shape the read path and the burst sequence. `ft_mode` selects flow-through or pipelined output. Flow-through gives a 2-1-1-1 burst and pipelined gives a 3-1-1-1 burst, counting the address-sampling edge as the first. `lin_order` selects a linear or an interleaved beat sequence, and the all-zero setting of both inputs is the default: interleaved, pipelined. Writes go through per-byte enables or a global write-all input. Each write byte carries a parity bit, and the parity is checked against an even or odd polarity.

The control sits in a three-state machine. `ST_DESEL` moves to `ST_READ` or `ST_WRITE` on a load with `cs` high. From `ST_READ` and `ST_WRITE`, a load with `cs` high picks `ST_READ` or `ST_WRITE` again from the write enables, and a load with `cs` low returns to `ST_DESEL`. A continue cycle (no load) picks `ST_READ` or `ST_WRITE` from the write enables of that cycle. Without a load, `ST_DESEL` stays in `ST_DESEL`.

Top module: `burst_sram`

## Requirements
- R1: While reset is held, and in the cycle after it, `dout_oe` and `par_err` are 0 and `dout` is 0. The machine starts in `ST_DESEL`.
- R2: All inputs are sampled on the rising clock edge. With `load`=1 and `cs`=1 on consecutive cycles, each cycle's address is read in turn with no wait cycle, and the read data leaves in consecutive cycles.
- R3: Read latency. When a read is sampled at edge n, the data is on `dout` with `dout_oe`=1 after edge n if `ft_mode`=1 (flow-through), and after edge n+1 if `ft_mode`=0 (pipelined). Each further beat follows one cycle later.
- R4: With `lin_order`=1, beat i of a burst addresses the low two bits `(start+i) mod 4`.
- R5: With `lin_order`=0, beat i addresses the low two bits `start XOR i`. Together with `ft_mode`=0, this is the default mode.
- R6: In a continue cycle (`load`=0) the beat counter steps only when `adv`=1, and with `adv`=0 the same word is accessed again. The address bits above bit 1 never change within a burst.
- R7: `wr_all`=1 writes every byte of the word, whatever the value of `wr_byte`.
- R8: With `wr_all`=0, bit b of `wr_byte` writes byte b (`din[8b+7:8b]`) and leaves the other bytes unchanged.
- R9: A write lands in the word addressed by its beat, including the later beats of a burst write, and a later read returns it.
- R10: Bit b of `din_par` is byte b's parity. `par_odd`=0 requires the XOR of the byte and its bit to be 0, and `par_odd`=1 requires it to be 1. A mismatch on an enabled byte sets `par_err` for one cycle, starting one cycle after the write is sampled, and the write still completes. A mismatch on a disabled byte is ignored.
- R11: A deselect (`load`=1, `cs`=0) sampled at edge n drops `dout_oe` after edge n in flow-through mode, and after edge n+1 in pipelined mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ft_mode | input | 1 | 1 = flow-through read, 0 = pipelined read |
| lin_order | input | 1 | 1 = linear burst, 0 = interleaved burst |
| par_odd | input | 1 | 1 = odd parity expected, 0 = even |
| load | input | 1 | Start an access at `addr` (or deselect when `cs`=0) |
| cs | input | 1 | Chip select, qualifies `load` |
| adv | input | 1 | Step the burst counter in a continue cycle |
| addr | input | AW | Word address |
| wr_all | input | 1 | Write all bytes |
| wr_byte | input | NB | Per-byte write enables |
| din | input | NB*BW | Write data |
| din_par | input | NB | Per-byte parity of write data |
| dout | output | NB*BW | Read data, 0 while not driving |
| dout_oe | output | 1 | Output drive enable for the shared data pad |
| par_err | output | 1 | One-cycle write parity error flag |

## Verification
The bench builds the block with AW=4, NB=2 and BW=8: a 16-word memory of two bytes per word. This makes the whole memory small enough to fill and to read back from every start address. In each of the four combinations of `ft_mode` and `lin_order`, it fills every word and bursts from all sixteen start addresses, so every wrap position of both orders is reached under both latencies. The two bytes are enough to check enabled and disabled bytes against each other for byte writes and parity errors under both polarities.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_st_e;

endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          lin,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] cur_addr
);
    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [1:0]    low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load) begin
            base_q <= start_addr;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + 2'd1;
        end
    end

    always_comb begin
        if (lin) low = base_q[1:0] + beat_q;
        else     low = base_q[1:0] ^ beat_q;
        cur_addr = {base_q[AW-1:2], low};
    end
endmodule

// File: rtl/bsram_par_chk.sv
module bsram_par_chk #(
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic [NB*BW-1:0] data,
    input  logic [NB-1:0]    par,
    input  logic [NB-1:0]    en,
    input  logic             odd,
    output logic             bad
);
    logic [NB-1:0] lane_bad;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane_bad[b] = en[b] && (((^data[b*BW +: BW]) ^ par[b]) != odd);
    end

    assign bad = |lane_bad;
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NB-1:0]    be,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (we && be[b]) mem[addr][b*BW +: BW] <= wdata[b*BW +: BW];
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ft_mode,
    input  logic             lin_order,
    input  logic             par_odd,
    input  logic             load,
    input  logic             cs,
    input  logic             adv,
    input  logic [AW-1:0]    addr,
    input  logic             wr_all,
    input  logic [NB-1:0]    wr_byte,
    input  logic [NB*BW-1:0] din,
    input  logic [NB-1:0]    din_par,
    output logic [NB*BW-1:0] dout,
    output logic             dout_oe,
    output logic             par_err
);
    localparam int DW = NB * BW;

    acc_st_e       st_q, st_d;
    logic          wr_any;
    logic          step;
    logic [NB-1:0] be_in, be_q;
    logic [DW-1:0] wd_q, rd_w, pipe_q;
    logic [NB-1:0] wp_q;
    logic          pipe_oe_q, perr_q, chk_bad;
    logic [AW-1:0] cur_addr;

    assign wr_any = wr_all | (|wr_byte);
    assign be_in  = wr_all ? {NB{1'b1}} : wr_byte;
    assign step   = (st_q != ST_DESEL) && !load && adv;

    bsram_burst_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .lin        (lin_order),
        .start_addr (addr),
        .cur_addr   (cur_addr)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DESEL: begin
                if (load && cs) st_d = wr_any ? ST_WRITE : ST_READ;
            end
            ST_READ, ST_WRITE: begin
                if (load && !cs) st_d = ST_DESEL;
                else             st_d = wr_any ? ST_WRITE : ST_READ;
            end
            default: st_d = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_DESEL;
        else        st_q <= st_d;
    end

    // registered write stage
    always_ff @(posedge clk) begin
        if (!rst_n) be_q <= '0;
        else        be_q <= be_in;
    end

    always_ff @(posedge clk) begin
        wd_q <= din;
        wp_q <= din_par;
    end

    bsram_array #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
        .clk   (clk),
        .we    (st_q == ST_WRITE),
        .be    (be_q),
        .addr  (cur_addr),
        .wdata (wd_q),
        .rdata (rd_w)
    );

    bsram_par_chk #(.NB(NB), .BW(BW)) u_par (
        .data (wd_q),
        .par  (wp_q),
        .en   (be_q),
        .odd  (par_odd),
        .bad  (chk_bad)
    );

    // output register stage and parity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q    <= '0;
            pipe_oe_q <= 1'b0;
            perr_q    <= 1'b0;
        end else begin
            pipe_q    <= rd_w;
            pipe_oe_q <= (st_q == ST_READ);
            perr_q    <= (st_q == ST_WRITE) && chk_bad;
        end
    end

    // outputs
    always_comb begin
        if (ft_mode) dout_oe = (st_q == ST_READ);
        else         dout_oe = pipe_oe_q;
        if (!dout_oe)     dout = '0;
        else if (ft_mode) dout = rd_w;
        else              dout = pipe_q;
        par_err = perr_q;
    end
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
    import bsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ft_mode,
    input logic          load,
    input logic          cs,
    input logic          wr_all,
    input logic [NB-1:0] wr_byte,
    input logic          dout_oe,
    input logic          par_err,
    input acc_st_e       st_q,
    input logic [AW-1:0] cur_addr
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!dout_oe && !par_err));

    p_flow_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_mode && load && cs && !wr_all && (wr_byte == '0)) |=> dout_oe);

    p_upper_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_DESEL) && !load) |=> $stable(cur_addr[AW-1:2]));

    p_perr_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> ($past(st_q) == ST_WRITE));

    p_desel_flow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_mode && load && !cs) |=> !dout_oe);

    p_desel_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ft_mode && load && !cs) |=> ##1 (!dout_oe || ft_mode));
endmodule

bind burst_sram bsram_chk #(.AW(AW), .NB(NB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ft_mode  (ft_mode),
    .load     (load),
    .cs       (cs),
    .wr_all   (wr_all),
    .wr_byte  (wr_byte),
    .dout_oe  (dout_oe),
    .par_err  (par_err),
    .st_q     (st_q),
    .cur_addr (cur_addr)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ft_mode = 1'b0, lin_order = 1'b0, par_odd = 1'b0;
    logic          load = 1'b0, cs = 1'b0, adv = 1'b0, wr_all = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] wr_byte = '0, din_par = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe, par_err;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] bm [16];

    always #4 clk = ~clk;

    burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ft_mode(ft_mode), .lin_order(lin_order),
        .par_odd(par_odd), .load(load), .cs(cs), .adv(adv), .addr(addr),
        .wr_all(wr_all), .wr_byte(wr_byte), .din(din), .din_par(din_par),
        .dout(dout), .dout_oe(dout_oe), .par_err(par_err)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] gpar(input logic [DW-1:0] d, input logic odd);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) p[b] = (^d[b*BW +: BW]) ^ odd;
        return p;
    endfunction

    function automatic logic [AW-1:0] seqa(input logic [AW-1:0] s, input int i, input logic lin);
        logic [1:0] lo;
        lo = lin ? (s[1:0] + 2'(i)) : (s[1:0] ^ 2'(i));
        return {s[AW-1:2], lo};
    endfunction

    task automatic drv(input logic l, input logic c, input logic a_v, input logic [AW-1:0] a,
                       input logic wa, input logic [NB-1:0] wb,
                       input logic [DW-1:0] d, input logic [NB-1:0] p);
        load = l; cs = c; adv = a_v; addr = a; wr_all = wa; wr_byte = wb; din = d; din_par = p;
    endtask

    task automatic idle();
        drv(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic desel();
        drv(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, '0, '0);
    endtask

    // back-to-back single writes of every word (R2, R9)
    task automatic fill(input int seed);
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k < 16) begin
                bm[k] = DW'(k * 37 + seed * 1000 + 16'h5a00);
                drv(1'b1, 1'b1, 1'b0, AW'(k), 1'b1, '0, bm[k], gpar(bm[k], par_odd));
            end else if (k == 16) desel();
            else idle();
        end
    endtask

    // four-beat read burst from start s; latency R3, order R4/R5, deselect R11
    task automatic rd_burst(input logic [AW-1:0] s);
        for (int k = 0; k < 7; k++) begin
            int beat;
            @(negedge clk);
            beat = ft_mode ? k - 1 : k - 2;
            if (beat >= 0 && beat < 4) begin
                chk("R3 oe in burst", DW'(dout_oe), DW'(1));
                if (lin_order) chk("R4 linear beat data", dout, bm[seqa(s, beat, 1'b1)]);
                else           chk("R5 interleaved beat data", dout, bm[seqa(s, beat, 1'b0)]);
            end else begin
                chk("R11 oe off outside burst", DW'(dout_oe), DW'(0));
            end
            if (k == 0)     drv(1'b1, 1'b1, 1'b0, s, 1'b0, '0, '0, '0);
            else if (k < 4) drv(1'b0, 1'b0, 1'b1, '0, 1'b0, '0, '0, '0);
            else if (k == 4) desel();
            else idle();
        end
    endtask

    // new address every cycle (R2)
    task automatic rd_stream();
        int lat;
        lat = ft_mode ? 1 : 2;
        for (int k = 0; k < 18; k++) begin
            int j;
            @(negedge clk);
            j = k - lat;
            if (j >= 0 && j < 16) begin
                chk("R2 streamed oe", DW'(dout_oe), DW'(1));
                chk("R2 streamed data", dout, bm[j]);
            end else begin
                chk("R2 streamed oe off", DW'(dout_oe), DW'(0));
            end
            if (k < 16)       drv(1'b1, 1'b1, 1'b0, AW'(k), 1'b0, '0, '0, '0);
            else if (k == 16) desel();
            else idle();
        end
    endtask

    // single write with parity-flag timing check (R10)
    task automatic wr_one(input string tag, input logic [AW-1:0] a, input logic wa,
                          input logic [NB-1:0] wb, input logic [DW-1:0] d,
                          input logic [NB-1:0] p, input logic exp_err);
        @(negedge clk);
        drv(1'b1, 1'b1, 1'b0, a, wa, wb, d, p);
        @(negedge clk);
        chk({tag, " R10 flag not early"}, DW'(par_err), DW'(0));
        desel();
        @(negedge clk);
        chk({tag, " R10 flag"}, DW'(par_err), DW'(exp_err));
        idle();
        @(negedge clk);
        chk({tag, " R10 flag one cycle"}, DW'(par_err), DW'(0));
    endtask

    // single flow-through read
    task automatic rd_one(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        drv(1'b1, 1'b1, 1'b0, a, 1'b0, '0, '0, '0);
        @(negedge clk);
        chk(tag, dout, exp);
        desel();
        @(negedge clk);
        idle();
    endtask

    initial begin
        logic [DW-1:0] w;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", DW'(dout_oe), DW'(0));
        chk("R1 perr in reset", DW'(par_err), DW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", DW'(dout_oe), DW'(0));
        chk("R1 dout after reset", dout, DW'(0));
        chk("R1 perr after reset", DW'(par_err), DW'(0));

        // sweep all mode combinations
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            ft_mode = m[0];
            lin_order = m[1];
            fill(m);
            for (int s = 0; s < 16; s++) rd_burst(AW'(s));
            rd_stream();
        end

        // burst write in linear and interleaved order (R9)
        for (int l = 0; l < 2; l++) begin
            @(negedge clk);
            ft_mode = 1'b0;
            lin_order = l[0];
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                w = DW'(16'hc000 + l * 256 + k * 17);
                if (k < 4) begin
                    bm[seqa(AW'(6), k, lin_order)] = w;
                    drv(k == 0, k == 0, k != 0, AW'(6), 1'b1, '0, w, gpar(w, par_odd));
                end else if (k == 4) desel();
                else idle();
            end
            rd_burst(AW'(6));
        end

        // adv held low repeats the word, then steps (R6)
        @(negedge clk);
        ft_mode = 1'b1;
        lin_order = 1'b1;
        @(negedge clk);
        drv(1'b1, 1'b1, 1'b0, AW'(11), 1'b0, '0, '0, '0);
        @(negedge clk);
        chk("R6 first word", dout, bm[11]);
        drv(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, '0, '0);
        @(negedge clk);
        chk("R6 hold repeats word", dout, bm[11]);
        drv(1'b0, 1'b0, 1'b1, '0, 1'b0, '0, '0, '0);
        @(negedge clk);
        chk("R6 step wraps in block", dout, bm[8]);
        desel();
        @(negedge clk);
        idle();

        // parity and byte enables
        par_odd = 1'b0;
        wr_one("R10 even ok", AW'(3), 1'b1, 2'b00, 16'h1234, gpar(16'h1234, 1'b0), 1'b0);
        bm[3] = 16'h1234;
        rd_one("R9 even write", AW'(3), bm[3]);
        wr_one("R8 disabled lane bad parity", AW'(3), 1'b0, 2'b01, 16'hab77,
               gpar(16'hab77, 1'b0) ^ 2'b10, 1'b0);
        bm[3] = 16'h1277;
        rd_one("R8 low byte only", AW'(3), bm[3]);
        wr_one("R10 enabled lane bad parity", AW'(3), 1'b0, 2'b10, 16'h9c00,
               gpar(16'h9c00, 1'b0) ^ 2'b10, 1'b1);
        bm[3] = 16'h9c77;
        rd_one("R10 write completes despite error", AW'(3), bm[3]);
        par_odd = 1'b1;
        wr_one("R10 odd ok", AW'(5), 1'b1, 2'b01, 16'h0f3c, gpar(16'h0f3c, 1'b1), 1'b0);
        bm[5] = 16'h0f3c;
        rd_one("R7 all bytes despite wr_byte", AW'(5), bm[5]);
        wr_one("R10 odd with even bits", AW'(5), 1'b1, 2'b00, 16'h5581, gpar(16'h5581, 1'b0), 1'b1);
        bm[5] = 16'h5581;
        rd_one("R10 odd error write completes", AW'(5), bm[5]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule